// File: doc/BRIEF.md
# Eight-bit ALU with Zero and Carry flags

This block is the arithmetic and logic stage of a small accumulator processor. Each cycle it takes the accumulator value, a memory operand and a four-bit operation code, and produces an eight-bit result at once through combinational logic. It also drives a write-enable that tells the register file whether the result should be stored. Two condition flags, Zero and Carry, are held in registers. They change on the rising clock edge when the flag-enable input is high, and an external branch unit reads them.

Carry is used consistently throughout. After an addition it is the unsigned carry out of the top bit. After a subtraction or comparison it is an unsigned borrow. Shifts and rotates treat it as a ninth bit. Operations that read Carry, namely add-with-carry and the two rotates, use the value registered before the edge. They can therefore consume the old Carry and replace it in the same cycle.

The operation decode has no states. A single combinational decoder turns the code into a control word, and one register process holds the two flags.

Top module: `alu8_core`

## Requirements
- R1: The codes are ADD=0, ADC=1, SUB=2, CMP=3, AND=4, OR=5, XOR=6, LOAD=7, MOVE=8, LSL=9, LSR=10, ROL=11, ROR=12, SEC=13, CLC=14, BTST=15. ADD gives result = (acc_in + mem_in) mod 256, and C becomes the unsigned carry out of bit 7.
- R2: ADC adds the registered C as carry-in, and C then takes the carry out of bit 7.
- R3: SUB and CMP compute acc_in − mem_in mod 256. C becomes 1 exactly when mem_in is unsigned-greater than acc_in.
- R4: wr_en is 0 for CMP, SEC, CLC and BTST, and 1 for every other code.
- R5: For codes 0 to 12, Z becomes 1 when the result is 0x00 and 0 otherwise. SEC, CLC and BTST leave Z unchanged.
- R6: AND, OR and XOR combine acc_in with mem_in bitwise. LOAD and MOVE pass mem_in through. All five leave C unchanged.
- R7: LSL and LSR shift acc_in by one place and fill the vacated bit with 0. C takes the bit shifted out (bit 7 for LSL, bit 0 for LSR).
- R8: ROL puts the old C into bit 0 and bit 7 into C. ROR puts the old C into bit 7 and bit 0 into C.
- R9: SEC sets C to 1 and CLC clears it. Both output acc_in as the result.
- R10: BTST copies mem_in[bit_sel] into C and outputs mem_in unchanged as the result.
- R11: While flag_en is 0, Z and C hold their values at the edge, and the result is still produced.
- R12: A synchronous reset clears Z and C at the edge, whatever flag_en is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag_en | input | 1 | Allows the flags to update at the edge |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| bit_sel | input | 3 | Bit index for BTST |
| result | output | 8 | Combinational result |
| wr_en | output | 1 | Result should be written back |
| z_flag | output | 1 | Registered Zero flag |
| c_flag | output | 1 | Registered Carry flag |

## Verification
Two functions can fall in the same cycle: reading the registered Carry into a result, through ADC, ROL or ROR, and overwriting that Carry at the edge that closes the cycle. The bench provokes this with back-to-back rotate and add-with-carry chains, and with a random stream in which flag_en is often low. Its scoreboard samples result before the edge and the flags after it. Each result is judged against the Carry the bench's own model held before the edge, and each flag against the model's updated value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_CMP  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_LOAD = 4'd7,
        OP_MOVE = 4'd8,
        OP_LSL  = 4'd9,
        OP_LSR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_SEC  = 4'd13,
        OP_CLC  = 4'd14,
        OP_BTST = 4'd15
    } op_e;

    typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_PASS} logic_sel_e;
    typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ROL, SH_ROR} shift_sel_e;
    typedef enum logic [2:0] {RS_ARITH, RS_LOGIC, RS_SHIFT, RS_ACC, RS_MEM} res_src_e;
    typedef enum logic [2:0] {CS_KEEP, CS_ARITH, CS_SHIFT, CS_ONE, CS_ZERO, CS_BIT} c_src_e;

    typedef struct packed {
        res_src_e   res_src;
        logic       sub;
        logic       use_cin;
        logic_sel_e lsel;
        shift_sel_e ssel;
        logic       z_upd;
        c_src_e     c_src;
        logic       wr;
    } ctl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  op_e  op_i,
    output ctl_t ctl_o
);

    always_comb begin
        ctl_o = '{res_src: RS_ACC, sub: 1'b0, use_cin: 1'b0, lsel: LG_PASS,
                  ssel: SH_LSL, z_upd: 1'b0, c_src: CS_KEEP, wr: 1'b1};
        unique case (op_i)
            OP_ADD: begin
                ctl_o.res_src = RS_ARITH;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_ARITH;
            end
            OP_ADC: begin
                ctl_o.res_src = RS_ARITH;
                ctl_o.use_cin = 1'b1;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_ARITH;
            end
            OP_SUB: begin
                ctl_o.res_src = RS_ARITH;
                ctl_o.sub     = 1'b1;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_ARITH;
            end
            OP_CMP: begin
                ctl_o.res_src = RS_ARITH;
                ctl_o.sub     = 1'b1;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_ARITH;
                ctl_o.wr      = 1'b0;
            end
            OP_AND: begin
                ctl_o.res_src = RS_LOGIC;
                ctl_o.lsel    = LG_AND;
                ctl_o.z_upd   = 1'b1;
            end
            OP_OR: begin
                ctl_o.res_src = RS_LOGIC;
                ctl_o.lsel    = LG_OR;
                ctl_o.z_upd   = 1'b1;
            end
            OP_XOR: begin
                ctl_o.res_src = RS_LOGIC;
                ctl_o.lsel    = LG_XOR;
                ctl_o.z_upd   = 1'b1;
            end
            OP_LOAD, OP_MOVE: begin
                ctl_o.res_src = RS_LOGIC;
                ctl_o.lsel    = LG_PASS;
                ctl_o.z_upd   = 1'b1;
            end
            OP_LSL: begin
                ctl_o.res_src = RS_SHIFT;
                ctl_o.ssel    = SH_LSL;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_SHIFT;
            end
            OP_LSR: begin
                ctl_o.res_src = RS_SHIFT;
                ctl_o.ssel    = SH_LSR;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_SHIFT;
            end
            OP_ROL: begin
                ctl_o.res_src = RS_SHIFT;
                ctl_o.ssel    = SH_ROL;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_SHIFT;
            end
            OP_ROR: begin
                ctl_o.res_src = RS_SHIFT;
                ctl_o.ssel    = SH_ROR;
                ctl_o.z_upd   = 1'b1;
                ctl_o.c_src   = CS_SHIFT;
            end
            OP_SEC: begin
                ctl_o.c_src   = CS_ONE;
                ctl_o.wr      = 1'b0;
            end
            OP_CLC: begin
                ctl_o.c_src   = CS_ZERO;
                ctl_o.wr      = 1'b0;
            end
            OP_BTST: begin
                ctl_o.res_src = RS_MEM;
                ctl_o.c_src   = CS_BIT;
                ctl_o.wr      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic             use_cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   cy;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign cy[0] = sub_i | (use_cin_i & cin_i);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        assign sum_o[gi]  = a_i[gi] ^ b_eff[gi] ^ cy[gi];
        assign cy[gi + 1] = (a_i[gi] & b_eff[gi]) | (cy[gi] & (a_i[gi] ^ b_eff[gi]));
    end

    // borrow is the inverted carry of a + ~b + 1
    assign cout_o = sub_i ? ~cy[WIDTH] : cy[WIDTH];

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int MSB  = WIDTH - 1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             cin_i,
    input  shift_sel_e       mode_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);

    always_comb begin
        res_o  = a_i;
        cout_o = 1'b0;
        unique case (mode_i)
            SH_LSL: begin
                res_o  = {a_i[MSB-1:0], 1'b0};
                cout_o = a_i[MSB];
            end
            SH_LSR: begin
                res_o  = {1'b0, a_i[MSB:1]};
                cout_o = a_i[0];
            end
            SH_ROL: begin
                res_o  = {a_i[MSB-1:0], cin_i};
                cout_o = a_i[MSB];
            end
            SH_ROR: begin
                res_o  = {cin_i, a_i[MSB:1]};
                cout_o = a_i[0];
            end
        endcase
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic z_upd_i,
    input  logic z_val_i,
    input  logic c_upd_i,
    input  logic c_val_i,
    output logic z_o,
    output logic c_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            z_o <= 1'b0;
            c_o <= 1'b0;
        end else if (en_i) begin
            if (z_upd_i) z_o <= z_val_i;
            if (c_upd_i) c_o <= c_val_i;
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int SELW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_en,
    input  logic [OPW-1:0]   op,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] mem_in,
    input  logic [SELW-1:0]  bit_sel,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             z_flag,
    output logic             c_flag
);

    ctl_t             ctl;
    logic [WIDTH-1:0] ar_res, lg_res, sh_res;
    logic             ar_c, sh_c, c_next;

    alu8_decode u_dec (
        .op_i  (op_e'(op)),
        .ctl_o (ctl)
    );

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i       (acc_in),
        .b_i       (mem_in),
        .cin_i     (c_flag),
        .use_cin_i (ctl.use_cin),
        .sub_i     (ctl.sub),
        .sum_o     (ar_res),
        .cout_o    (ar_c)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .a_i    (acc_in),
        .cin_i  (c_flag),
        .mode_i (ctl.ssel),
        .res_o  (sh_res),
        .cout_o (sh_c)
    );

    always_comb begin
        unique case (ctl.lsel)
            LG_AND:  lg_res = acc_in & mem_in;
            LG_OR:   lg_res = acc_in | mem_in;
            LG_XOR:  lg_res = acc_in ^ mem_in;
            LG_PASS: lg_res = mem_in;
        endcase
    end

    always_comb begin
        result = acc_in;
        unique case (ctl.res_src)
            RS_ARITH: result = ar_res;
            RS_LOGIC: result = lg_res;
            RS_SHIFT: result = sh_res;
            RS_ACC:   result = acc_in;
            RS_MEM:   result = mem_in;
            default:  result = acc_in;
        endcase
    end

    always_comb begin
        c_next = c_flag;
        unique case (ctl.c_src)
            CS_KEEP:  c_next = c_flag;
            CS_ARITH: c_next = ar_c;
            CS_SHIFT: c_next = sh_c;
            CS_ONE:   c_next = 1'b1;
            CS_ZERO:  c_next = 1'b0;
            CS_BIT:   c_next = mem_in[bit_sel];
            default:  c_next = c_flag;
        endcase
    end

    assign wr_en = ctl.wr;

    alu8_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .en_i    (flag_en),
        .z_upd_i (ctl.z_upd),
        .z_val_i (result == '0),
        .c_upd_i (ctl.c_src != CS_KEEP),
        .c_val_i (c_next),
        .z_o     (z_flag),
        .c_o     (c_flag)
    );

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int SELW = $clog2(WIDTH),
    localparam int MSB  = WIDTH - 1
) (
    input logic             clk,
    input logic             rst,
    input logic             flag_en,
    input logic [OPW-1:0]   op,
    input logic [WIDTH-1:0] acc_in,
    input logic [WIDTH-1:0] mem_in,
    input logic [SELW-1:0]  bit_sel,
    input logic [WIDTH-1:0] result,
    input logic             wr_en,
    input logic             z_flag,
    input logic             c_flag
);

    // R12
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!z_flag && !c_flag));

    // R11
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_en |=> (z_flag == $past(z_flag) && c_flag == $past(c_flag)));

    // R9
    sec_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en && op_e'(op) == OP_SEC) |=> c_flag);

    // R9
    clc_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en && op_e'(op) == OP_CLC) |=> !c_flag);

    // R6
    logic_keeps_c_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en && op_e'(op) inside {OP_AND, OP_OR, OP_XOR, OP_LOAD, OP_MOVE})
        |=> c_flag == $past(c_flag));

    // R5
    zero_track_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en && !(op_e'(op) inside {OP_SEC, OP_CLC, OP_BTST}))
        |=> z_flag == ($past(result) == '0));

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_e'(op) == OP_CMP) |-> !wr_en);

    // R8
    rol_feed_chk: assert property (@(posedge clk) disable iff (rst)
        (op_e'(op) == OP_ROL) |-> result[0] == c_flag);

    // R8
    ror_feed_chk: assert property (@(posedge clk) disable iff (rst)
        (op_e'(op) == OP_ROR) |-> result[MSB] == c_flag);

    // R10
    btst_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en && op_e'(op) == OP_BTST) |=> c_flag == $past(mem_in[bit_sel]));

    // R3
    borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_en && op_e'(op) == OP_SUB) |=> c_flag == ($past(mem_in) > $past(acc_in)));

endmodule

bind alu8_core alu8_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .flag_en (flag_en),
    .op      (op),
    .acc_in  (acc_in),
    .mem_in  (mem_in),
    .bit_sel (bit_sel),
    .result  (result),
    .wr_en   (wr_en),
    .z_flag  (z_flag),
    .c_flag  (c_flag)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;

    localparam logic [3:0] K_ADD = 4'd0,  K_ADC = 4'd1,  K_SUB = 4'd2,  K_CMP = 4'd3;
    localparam logic [3:0] K_AND = 4'd4,  K_OR  = 4'd5,  K_XOR = 4'd6,  K_LOAD = 4'd7;
    localparam logic [3:0] K_MOVE = 4'd8, K_LSL = 4'd9,  K_LSR = 4'd10, K_ROL = 4'd11;
    localparam logic [3:0] K_ROR = 4'd12, K_SEC = 4'd13, K_CLC = 4'd14, K_BTST = 4'd15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flag_en = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] mem_in = 8'd0;
    logic [2:0] bit_sel = 3'd0;
    logic [7:0] result;
    logic       wr_en, z_flag, c_flag;

    always #5 clk = ~clk;

    alu8_core #(.WIDTH(8)) u0 (
        .clk(clk), .rst(rst), .flag_en(flag_en), .op(op), .acc_in(acc_in),
        .mem_in(mem_in), .bit_sel(bit_sel), .result(result), .wr_en(wr_en),
        .z_flag(z_flag), .c_flag(c_flag)
    );

    typedef struct {
        logic [7:0] res;
        logic       wr;
        logic       z;
        logic       c;
        string      rtag;
        string      ztag;
        string      ctag;
    } item_t;

    item_t sb[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic  mz = 1'b0;
    logic  mc = 1'b0;

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Reference model built from R1..R12, pushed to the scoreboard
    task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] m,
                         input logic [2:0] bs, input logic fe);
        item_t      it;
        logic [8:0] s9;
        logic [7:0] r;
        logic       wr, zu, cu, nc;
        string      tag;
        @(negedge clk);
        op = o; acc_in = a; mem_in = m; bit_sel = bs; flag_en = fe;
        wr = 1'b1; zu = 1'b1; cu = 1'b0; nc = mc; r = a; tag = "R1";
        case (o)
            K_ADD:  begin s9 = {1'b0, a} + {1'b0, m}; r = s9[7:0]; nc = s9[8]; cu = 1'b1; tag = "R1"; end
            K_ADC:  begin s9 = {1'b0, a} + {1'b0, m} + {8'd0, mc}; r = s9[7:0]; nc = s9[8]; cu = 1'b1; tag = "R2"; end
            K_SUB:  begin r = a - m; nc = (m > a); cu = 1'b1; tag = "R3"; end
            K_CMP:  begin r = a - m; nc = (m > a); cu = 1'b1; wr = 1'b0; tag = "R4"; end
            K_AND:  begin r = a & m; tag = "R6"; end
            K_OR:   begin r = a | m; tag = "R6"; end
            K_XOR:  begin r = a ^ m; tag = "R6"; end
            K_LOAD, K_MOVE: begin r = m; tag = "R6"; end
            K_LSL:  begin r = {a[6:0], 1'b0}; nc = a[7]; cu = 1'b1; tag = "R7"; end
            K_LSR:  begin r = {1'b0, a[7:1]}; nc = a[0]; cu = 1'b1; tag = "R7"; end
            K_ROL:  begin r = {a[6:0], mc}; nc = a[7]; cu = 1'b1; tag = "R8"; end
            K_ROR:  begin r = {mc, a[7:1]}; nc = a[0]; cu = 1'b1; tag = "R8"; end
            K_SEC:  begin r = a; nc = 1'b1; cu = 1'b1; zu = 1'b0; wr = 1'b0; tag = "R9"; end
            K_CLC:  begin r = a; nc = 1'b0; cu = 1'b1; zu = 1'b0; wr = 1'b0; tag = "R9"; end
            default: begin r = m; nc = m[bs]; cu = 1'b1; zu = 1'b0; wr = 1'b0; tag = "R10"; end
        endcase
        it.res  = r;
        it.wr   = wr;
        it.z    = (fe && zu) ? (r == 8'd0) : mz;
        it.c    = (fe && cu) ? nc : mc;
        it.rtag = tag;
        it.ztag = !fe ? "R11" : (zu ? "R5" : tag);
        it.ctag = !fe ? "R11" : tag;
        sb.push_back(it);
        mz = it.z;
        mc = it.c;
    endtask

    // Monitor: result before the edge, flags after it
    initial begin
        logic [7:0] cr;
        logic       cw;
        item_t      it;
        forever begin
            @(negedge clk);
            #3;
            cr = result;
            cw = wr_en;
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(it.rtag, "result", cr, it.res);
                chk("R4", "wr_en", {7'd0, cw}, {7'd0, it.wr});
                chk(it.ztag, "z_flag", {7'd0, z_flag}, {7'd0, it.z});
                chk(it.ctag, "c_flag", {7'd0, c_flag}, {7'd0, it.c});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog run hung got no end expected end");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R12 reset state
        chk("R12", "z_flag after reset", {7'd0, z_flag}, 8'd0);
        chk("R12", "c_flag after reset", {7'd0, c_flag}, 8'd0);

        // R1 additions incl. carry cases
        drive(K_ADD, 8'h10, 8'h20, 3'd0, 1'b1);
        drive(K_ADD, 8'h80, 8'h80, 3'd0, 1'b1);
        drive(K_ADD, 8'hF0, 8'h20, 3'd0, 1'b1);
        drive(K_ADD, 8'h7F, 8'h01, 3'd0, 1'b1);
        // R2 add-with-carry consuming old C
        drive(K_SEC, 8'h00, 8'h00, 3'd0, 1'b1);
        drive(K_ADC, 8'h01, 8'h01, 3'd0, 1'b1);
        drive(K_SEC, 8'h00, 8'h00, 3'd0, 1'b1);
        drive(K_ADC, 8'hFF, 8'h00, 3'd0, 1'b1);
        drive(K_ADC, 8'h00, 8'h00, 3'd0, 1'b1);
        // R3 borrow
        drive(K_SUB, 8'h05, 8'h07, 3'd0, 1'b1);
        drive(K_SUB, 8'h07, 8'h05, 3'd0, 1'b1);
        drive(K_SUB, 8'h05, 8'h05, 3'd0, 1'b1);
        // R4 compare writes nothing
        drive(K_CMP, 8'h10, 8'h20, 3'd0, 1'b1);
        drive(K_CMP, 8'h42, 8'h42, 3'd0, 1'b1);
        // R6 logic keeps C (set first)
        drive(K_SEC, 8'h00, 8'h00, 3'd0, 1'b1);
        drive(K_AND, 8'hF0, 8'h0F, 3'd0, 1'b1);
        drive(K_OR,  8'hA0, 8'h05, 3'd0, 1'b1);
        drive(K_XOR, 8'h5A, 8'h5A, 3'd0, 1'b1);
        drive(K_LOAD, 8'h33, 8'h00, 3'd0, 1'b1);
        drive(K_MOVE, 8'h00, 8'h81, 3'd0, 1'b1);
        // R7 logical shifts
        drive(K_LSL, 8'h81, 8'h00, 3'd0, 1'b1);
        drive(K_LSR, 8'h01, 8'h00, 3'd0, 1'b1);
        drive(K_LSR, 8'h80, 8'h00, 3'd0, 1'b1);
        // R8 rotate chains through C
        drive(K_SEC, 8'h00, 8'h00, 3'd0, 1'b1);
        drive(K_ROL, 8'h80, 8'h00, 3'd0, 1'b1);
        drive(K_ROL, 8'h00, 8'h00, 3'd0, 1'b1);
        drive(K_ROR, 8'h01, 8'h00, 3'd0, 1'b1);
        drive(K_ROR, 8'h00, 8'h00, 3'd0, 1'b1);
        // R9 and R5: carry ops keep Z
        drive(K_LOAD, 8'h00, 8'h00, 3'd0, 1'b1);
        drive(K_SEC, 8'h12, 8'h00, 3'd0, 1'b1);
        drive(K_CLC, 8'h34, 8'h00, 3'd0, 1'b1);
        // R10 bit test
        drive(K_BTST, 8'h00, 8'h20, 3'd5, 1'b1);
        drive(K_BTST, 8'h00, 8'h20, 3'd4, 1'b1);
        drive(K_BTST, 8'h00, 8'h80, 3'd7, 1'b1);
        // R11 flags hold with enable low
        drive(K_SEC, 8'h00, 8'h00, 3'd0, 1'b0);
        drive(K_ADD, 8'h00, 8'h00, 3'd0, 1'b0);
        drive(K_ROL, 8'h40, 8'h00, 3'd0, 1'b0);

        // R12 reset wins over a flag update
        drive(K_SEC, 8'h00, 8'h00, 3'd0, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b1; op = K_SEC; flag_en = 1'b1;
        @(posedge clk);
        #1;
        chk("R12", "c_flag under reset", {7'd0, c_flag}, 8'd0);
        chk("R12", "z_flag under reset", {7'd0, z_flag}, 8'd0);
        @(negedge clk);
        rst = 1'b0; flag_en = 1'b0;
        mz = 1'b0;
        mc = 1'b0;

        // Mixed stream, same-cycle read and overwrite of C
        for (int i = 0; i < 400; i++) begin
            drive(4'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), ($urandom % 4) != 0);
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule